// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags and Comparisons

This block adds or subtracts two W-bit two's-complement operands, chosen by a single select input, and returns the W-bit result. It also returns four condition flags: zero, negative, carry and overflow. From those flags alone it decodes ten comparison outputs: six signed and four unsigned.

A single adder handles both operations. For subtraction the second operand is bit-inverted and the adder's carry input is forced to one. After a subtraction the compare outputs give the ordering of A against B.

All outputs are registered, so a result appears one clock after its operands are presented. A synchronous active-high reset clears every output register.

Top module: `acu_addsub_cmp`

## Requirements
- R1: With sub_i=0 the result is (A+B) mod 2^W. With sub_i=1 it is (A-B) mod 2^W, formed as A + ~B + 1 with the one supplied as adder carry-in. The result appears on the clock edge after the operands are sampled.
- R2: z_o is 1 exactly when every result bit is 0.
- R3: n_o equals the most significant result bit.
- R4: c_o is the carry out of the top adder bit. For addition it is 1 when A+B exceeds 2^W-1 as unsigned values. For subtraction it is 1 when A >= B unsigned, meaning no borrow occurred.
- R5: v_o is 1 when the sign bits of A and of the effective second operand (B for addition, ~B for subtraction) agree and the result sign differs from them. This is equivalent to the exact signed result lying outside [-2^(W-1), 2^(W-1)-1].
- R6: The signed compares decode the flags as follows: lt_o = n^v, le_o = z|(n^v), eq_o = z, ne_o = ~z, ge_o = ~(n^v), gt_o = ~(z|(n^v)). After a subtraction they give the signed ordering of A against B.
- R7: The unsigned compares decode the flags as follows: ltu_o = ~c, leu_o = ~c|z, geu_o = c, gtu_o = c&~z. After a subtraction they give the unsigned ordering of A against B.
- R8: While rst is high at a clock edge, every output register is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| sub_i | input | 1 | 1 selects A-B, 0 selects A+B |
| res_o | output | W | Registered result |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| c_o | output | 1 | Carry flag (no-borrow flag on subtract) |
| v_o | output | 1 | Signed overflow flag |
| lt_o | output | 1 | Signed less than |
| le_o | output | 1 | Signed less or equal |
| eq_o | output | 1 | Equal |
| ne_o | output | 1 | Not equal |
| ge_o | output | 1 | Signed greater or equal |
| gt_o | output | 1 | Signed greater than |
| ltu_o | output | 1 | Unsigned less than |
| leu_o | output | 1 | Unsigned less or equal |
| geu_o | output | 1 | Unsigned greater or equal |
| gtu_o | output | 1 | Unsigned greater than |

## Verification
Directed operands pair every value from the set {zero, one, largest positive, most negative, all ones} with every other in both modes. These pairs separate signed from unsigned ordering, since the most negative value is large when read unsigned. They also drive the overflow and carry flags to their boundaries: all ones plus one, largest positive plus one, and most negative minus one. Random operands then cover carry chains that stop at varied positions and cross group boundaries, which shows whether the group bypass path and the in-group ripple path agree. Each output is compared against signed and unsigned arithmetic done at integer precision.

// File: rtl/acu_pkg.sv
package acu_pkg;
  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } acu_flags_t;

  typedef struct packed {
    logic lt;
    logic le;
    logic eq;
    logic ne;
    logic ge;
    logic gt;
    logic ltu;
    logic leu;
    logic geu;
    logic gtu;
  } acu_cmp_t;
endpackage

// File: rtl/acu_bypass_adder.sv
module acu_bypass_adder #(
  parameter int W   = 8,
  parameter int GRP = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int NGRP = (W + GRP - 1) / GRP;

  logic [W-1:0] p;
  logic [W-1:0] g;
  logic [W:0]   c;

  assign p    = a ^ b;
  assign g    = a & b;
  assign c[0] = cin;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    localparam int LO   = gi * GRP;
    localparam int HI   = ((LO + GRP) > W) ? (W - 1) : (LO + GRP - 1);
    localparam int SPAN = HI - LO + 1;
    logic [SPAN:0] rc;
    logic          skip;

    assign rc[0] = c[LO];
    for (genvar k = 0; k < SPAN; k++) begin : g_bit
      assign rc[k+1] = g[LO+k] | (p[LO+k] & rc[k]);
      if (k > 0) begin : g_int
        assign c[LO+k] = rc[k];
      end
    end
    // whole group propagates: carry jumps straight across
    assign skip     = &p[HI:LO];
    assign c[HI+1]  = skip ? c[LO] : rc[SPAN];
  end

  assign sum  = p ^ c[W-1:0];
  assign cout = c[W];
endmodule

// File: rtl/acu_flag_gen.sv
module acu_flag_gen
  import acu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] sum,
  input  logic         cout,
  input  logic         a_msb,
  input  logic         beff_msb,
  output acu_flags_t   flags
);
  always_comb begin
    flags.z = ~|sum;
    flags.n = sum[W-1];
    flags.c = cout;
    flags.v = (a_msb == beff_msb) && (sum[W-1] != a_msb);
  end
endmodule

// File: rtl/acu_cmp_decode.sv
module acu_cmp_decode
  import acu_pkg::*;
(
  input  acu_flags_t flags,
  output acu_cmp_t   cmp
);
  logic sless;

  always_comb begin
    sless    = flags.n ^ flags.v;
    cmp.lt   = sless;
    cmp.le   = flags.z | sless;
    cmp.eq   = flags.z;
    cmp.ne   = ~flags.z;
    cmp.ge   = ~sless;
    cmp.gt   = ~(flags.z | sless);
    cmp.ltu  = ~flags.c;
    cmp.leu  = ~flags.c | flags.z;
    cmp.geu  = flags.c;
    cmp.gtu  = flags.c & ~flags.z;
  end
endmodule

// File: rtl/acu_addsub_cmp.sv
module acu_addsub_cmp
  import acu_pkg::*;
#(
  parameter int W   = 8,
  parameter int GRP = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         z_o,
  output logic         n_o,
  output logic         c_o,
  output logic         v_o,
  output logic         lt_o,
  output logic         le_o,
  output logic         eq_o,
  output logic         ne_o,
  output logic         ge_o,
  output logic         gt_o,
  output logic         ltu_o,
  output logic         leu_o,
  output logic         geu_o,
  output logic         gtu_o
);
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic         cout;
  acu_flags_t   flags;
  acu_cmp_t     cmp;
  acu_flags_t   flags_q;
  acu_cmp_t     cmp_q;
  logic         live_q;

  assign b_eff = sub_i ? ~b_i : b_i;

  acu_bypass_adder #(.W(W), .GRP(GRP)) u_add (
    .a(a_i), .b(b_eff), .cin(sub_i), .sum(sum), .cout(cout)
  );

  acu_flag_gen #(.W(W)) u_flag (
    .sum(sum), .cout(cout), .a_msb(a_i[W-1]), .beff_msb(b_eff[W-1]),
    .flags(flags)
  );

  acu_cmp_decode u_cmp (.flags(flags), .cmp(cmp));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      flags_q <= '0;
      cmp_q   <= '0;
      live_q  <= 1'b0;
    end else begin
      res_o   <= sum;
      flags_q <= flags;
      cmp_q   <= cmp;
      live_q  <= 1'b1;
    end
  end

  assign z_o   = flags_q.z;
  assign n_o   = flags_q.n;
  assign c_o   = flags_q.c;
  assign v_o   = flags_q.v;
  assign lt_o  = cmp_q.lt;
  assign le_o  = cmp_q.le;
  assign eq_o  = cmp_q.eq;
  assign ne_o  = cmp_q.ne;
  assign ge_o  = cmp_q.ge;
  assign gt_o  = cmp_q.gt;
  assign ltu_o = cmp_q.ltu;
  assign leu_o = cmp_q.leu;
  assign geu_o = cmp_q.geu;
  assign gtu_o = cmp_q.gtu;

  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
    live_q |-> res_o == $past(sub_i ? (a_i - b_i) : (a_i + b_i)));  // R1
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    live_q |-> z_o == (res_o == '0));  // R2
  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst)
    live_q |-> n_o == res_o[W-1]);  // R3
  AST_CARRY_ADD: assert property (@(posedge clk) disable iff (rst)
    (live_q && !$past(sub_i)) |-> c_o == ($past(a_i) > ~$past(b_i)));  // R4
  AST_CARRY_SUB: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(sub_i)) |-> c_o == ($past(a_i) >= $past(b_i)));  // R4
  AST_SIGNED_LT: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(sub_i)) |-> lt_o == ($signed($past(a_i)) < $signed($past(b_i))));  // R6
  AST_UNSIGNED_LT: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(sub_i)) |-> ltu_o == ($past(a_i) < $past(b_i)));  // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (res_o == '0 && !z_o && !gt_o && !gtu_o));  // R8
endmodule

// File: tb/acu_addsub_cmp_tb_top.sv
module acu_addsub_cmp_tb_top;
  localparam int W = 8;
  localparam int MAXU = (1 << W) - 1;
  localparam int SMAX = (1 << (W - 1)) - 1;
  localparam int SMIN = -(1 << (W - 1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic sub_i = 1'b0;
  logic [W-1:0] res_o;
  logic z_o, n_o, c_o, v_o;
  logic lt_o, le_o, eq_o, ne_o, ge_o, gt_o, ltu_o, leu_o, geu_o, gtu_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  acu_addsub_cmp #(.W(W), .GRP(4)) dut_i (
    .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .sub_i(sub_i),
    .res_o(res_o), .z_o(z_o), .n_o(n_o), .c_o(c_o), .v_o(v_o),
    .lt_o(lt_o), .le_o(le_o), .eq_o(eq_o), .ne_o(ne_o), .ge_o(ge_o),
    .gt_o(gt_o), .ltu_o(ltu_o), .leu_o(leu_o), .geu_o(geu_o), .gtu_o(gtu_o)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (a=%0h b=%0h sub=%0b)",
               tag, act, exp, a_i, b_i, sub_i);
    end
  endtask

  task automatic run_vec(logic [W-1:0] a, logic [W-1:0] b, logic sub);
    int ua, ub, sa, sb, exact;
    logic [W-1:0] er;
    logic ez, en, ec, ev, sl;
    logic [5:0] es;
    logic [3:0] eu;
    @(negedge clk);
    a_i = a; b_i = b; sub_i = sub;
    ua = int'(a); ub = int'(b);
    sa = int'($signed(a)); sb = int'($signed(b));
    er = sub ? W'(ua - ub) : W'(ua + ub);
    exact = sub ? (sa - sb) : (sa + sb);
    ez = (er == '0);
    en = er[W-1];
    ec = sub ? (ua >= ub) : ((ua + ub) > MAXU);
    ev = (exact > SMAX) || (exact < SMIN);
    if (sub) begin
      es = {sa < sb, sa <= sb, sa == sb, sa != sb, sa >= sb, sa > sb};
      eu = {ua < ub, ua <= ub, ua >= ub, ua > ub};
    end else begin
      sl = en ^ ev;
      es = {sl, ez | sl, ez, ~ez, ~sl, ~(ez | sl)};
      eu = {~ec, ~ec | ez, ec, ec & ~ez};
    end
    @(negedge clk);
    check("R1 result", int'(res_o), int'(er));
    check("R2 zero", int'(z_o), int'(ez));
    check("R3 negative", int'(n_o), int'(en));
    check("R4 carry", int'(c_o), int'(ec));
    check("R5 overflow", int'(v_o), int'(ev));
    check("R6 signed compares", int'({lt_o, le_o, eq_o, ne_o, ge_o, gt_o}), int'(es));
    check("R7 unsigned compares", int'({ltu_o, leu_o, geu_o, gtu_o}), int'(eu));
  endtask

  initial begin
    automatic logic [W-1:0] corner [5];
    corner[0] = '0;
    corner[1] = W'(1);
    corner[2] = W'(SMAX);
    corner[3] = {1'b1, {(W-1){1'b0}}};
    corner[4] = '1;
    void'($urandom(32'd20240611));
    a_i = '1; b_i = W'(1); sub_i = 1'b0;
    repeat (3) @(negedge clk);
    // R8: outputs held clear while reset is high
    check("R8 reset result", int'(res_o), 0);
    check("R8 reset flags", int'({z_o, n_o, c_o, v_o}), 0);
    check("R8 reset compares", int'({lt_o, le_o, eq_o, ne_o, ge_o, gt_o,
                                     ltu_o, leu_o, geu_o, gtu_o}), 0);
    rst = 1'b0;
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run_vec(corner[i], corner[j], s[0]);
    for (int k = 0; k < 3000; k++)
      run_vec(W'($urandom), W'($urandom), 1'($urandom));
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule